// File: doc/BRIEF.md
# Parallel Camera Capture Controller

This block takes the 8-bit parallel output of an image sensor together with its pixel clock and its two sync lines, decides which bytes belong to the picture, and packs those bytes four at a time into 32-bit words. The words leave on a valid/ready stream meant for a DMA engine. The pixel clock, the syncs and the data are treated as ordinary inputs sampled by the system clock. Crossing between clock domains is left to the integrator.

Control inputs choose how the sensor's timing is read:

- the level of each sync line that marks blanking;
- the pixel-clock edge on which data is taken;
- uncompressed mode or JPEG mode, where the horizontal sync only gates data;
- an optional crop window;
- continuous capture or a single-frame snapshot.

The block reports every frame start and frame end. In snapshot mode it drops its own capture enable once the frame is done. If a finished word cannot be handed over because the stream is stalled, a sticky overrun flag is raised.

Top module: `cam_capture`

## Requirements
- R1: `cfg_vs_pol` is the `cam_vsync` level that means vertical blanking (0 = blanking while low, 1 = blanking while high). No byte is captured while `cam_vsync` is at that level.
- R2: `cfg_hs_pol` is the `cam_hsync` level that means horizontal blanking (0 = low, 1 = high). No byte is captured while `cam_hsync` is at that level.
- R3: Data, syncs and pixel-clock edges are all seen through one register stage. A byte is taken on the rising edge of `pclk` when `cfg_pclk_rise`=1, and on the falling edge when it is 0.
- R4: Four captured bytes form one word, with the first byte in `out_data[7:0]` and the fourth in `out_data[31:24]`. A partly filled word is discarded at the next frame start.
- R5: With `cfg_crop_en`=1 and `cfg_jpeg`=0, a byte is captured only when both of the following hold:
  - its column (counted from 0 at the first active byte of a line) is in [`crop_col`, `crop_col`+`crop_width`);
  - its line (counted from 0 at the first line of a frame) is in [`crop_line`, `crop_line`+`crop_height`).
- R6: A crop window that reaches past the picture yields only the part that overlaps the picture.
- R7: With `cfg_jpeg`=1, every byte with both syncs out of blanking is captured, even inside a line that has gaps. The crop settings have no effect in this mode.
- R8: With `cfg_snapshot`=0 and `cap_en`=1, every frame that starts while enabled is captured, back to back.
- R9: With `cfg_snapshot`=1, a `cap_set` that arrives mid-frame does not capture the rest of that frame. Capture starts at the next frame start, covers one frame, and clears `cap_en` in the same cycle as that frame's `frame_end` pulse.
- R10: `frame_start` and `frame_end` are one-cycle pulses, independent of `cap_en`. `frame_start` fires when `cam_vsync` leaves its blanking level, and `frame_end` fires when it returns to that level.
- R11: While `out_valid`=1 and `out_ready`=0, `out_valid` stays high and `out_data` is held.
- R12: A word completed while the output still holds an unaccepted word is dropped, and `overrun` is set. `overrun` stays set until `cap_set`.
- R13: After reset, `out_valid`, `cap_en`, `overrun`, `frame_start` and `frame_end` are 0. `cap_clr` takes priority over `cap_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pclk | input | 1 | Sensor pixel clock, sampled |
| cam_vsync | input | 1 | Sensor vertical sync |
| cam_hsync | input | 1 | Sensor horizontal sync |
| cam_data | input | 8 | Sensor pixel byte |
| cfg_vs_pol | input | 1 | Vertical blanking level |
| cfg_hs_pol | input | 1 | Horizontal blanking level |
| cfg_pclk_rise | input | 1 | 1: rising capture edge, 0: falling |
| cfg_jpeg | input | 1 | JPEG mode |
| cfg_crop_en | input | 1 | Crop window enable |
| cfg_snapshot | input | 1 | 1: single frame, 0: continuous |
| crop_col | input | CNT_W | First captured column |
| crop_line | input | CNT_W | First captured line |
| crop_width | input | CNT_W | Window width in bytes |
| crop_height | input | CNT_W | Window height in lines |
| cap_set | input | 1 | Pulse: set capture enable, clear overrun |
| cap_clr | input | 1 | Pulse: clear capture enable |
| cap_en | output | 1 | Capture enable state |
| frame_start | output | 1 | Frame start pulse |
| frame_end | output | 1 | Frame end pulse |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Output word accepted |
| out_data | output | 32 | Packed output word |
| overrun | output | 1 | Sticky word-loss flag |

## Verification
The bound checker watches the stream-side rules on every cycle:

- a stalled word is held with its data;
- `frame_start` and `frame_end` never coincide;
- `cap_en` falls only on a frame end or after `cap_clr`;
- `overrun` rises only on a stalled completion and then stays set until `cap_set`.

Which bytes are captured can only be shown by the bench's scenarios. Each scenario drives whole frames and compares the packed words against values it predicts for that case: both sync polarities, both pixel-clock edges, crop windows inside and past the picture, JPEG lines with gaps, and snapshot timing relative to a mid-frame enable.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;
    localparam int unsigned PIX_W = 8;

    // sampled sensor pins
    typedef struct packed {
        logic             vs;
        logic             hs;
        logic [PIX_W-1:0] d;
    } cam_pins_t;

    // static configuration
    typedef struct packed {
        logic vs_pol;
        logic hs_pol;
        logic pclk_rise;
        logic jpeg;
        logic crop_en;
        logic snapshot;
    } cam_cfg_t;

    // one accepted byte
    typedef struct packed {
        logic             valid;
        logic [PIX_W-1:0] d;
    } cam_byte_t;

    function automatic logic at_blank(input logic pin, input logic pol);
        return pin == pol;
    endfunction
endpackage

// File: rtl/cam_pclk_sampler.sv
module cam_pclk_sampler
    import cam_cap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pclk,
    input  cam_pins_t pins,
    input  logic      rise_sel,
    output logic      strobe,
    output cam_pins_t sample
);
    cam_pins_t pins_q;
    logic      pclk_q;
    logic      pclk_qq;

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q  <= '0;
            pclk_q  <= 1'b0;
            pclk_qq <= 1'b0;
        end else begin
            pins_q  <= pins;
            pclk_q  <= pclk;
            pclk_qq <= pclk_q;
        end
    end

    always_comb begin
        if (rise_sel) strobe = pclk_q & ~pclk_qq;
        else          strobe = ~pclk_q & pclk_qq;
        sample = pins_q;
    end
endmodule

// File: rtl/cam_frame_ctrl.sv
module cam_frame_ctrl
    import cam_cap_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  cam_pins_t        sample,
    input  cam_cfg_t         cfg,
    input  logic [CNT_W-1:0] win_col,
    input  logic [CNT_W-1:0] win_line,
    input  logic [CNT_W-1:0] win_w,
    input  logic [CNT_W-1:0] win_h,
    input  logic             en_set,
    input  logic             en_clr,
    output cam_byte_t        byte_o,
    output logic             sof,
    output logic             eof,
    output logic             en_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             vsb_q, hsb_q, grabbing;
    logic [CNT_W-1:0] col, line;
    logic             vs_b, hs_b, fs, fe, cap_now, in_win, take;
    logic [CNT_W-1:0] cur_col, cur_line;

    function automatic logic in_span(input logic [CNT_W-1:0] pos,
                                     input logic [CNT_W-1:0] start,
                                     input logic [CNT_W-1:0] len);
        logic [CNT_W:0] stop;
        stop = {1'b0, start} + {1'b0, len};
        return (pos >= start) && ({1'b0, pos} < stop);
    endfunction

    always_comb begin
        vs_b     = at_blank(sample.vs, cfg.vs_pol);
        hs_b     = at_blank(sample.hs, cfg.hs_pol);
        fs       = strobe & vsb_q & ~vs_b;
        fe       = strobe & ~vsb_q & vs_b;
        cur_col  = fs ? '0 : col;
        cur_line = fs ? '0 : line;
        cap_now  = fs ? en_q : grabbing;
        in_win   = cfg.jpeg | ~cfg.crop_en |
                   (in_span(cur_col, win_col, win_w) & in_span(cur_line, win_line, win_h));
        take     = strobe & ~vs_b & ~hs_b & cap_now & in_win;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vsb_q    <= 1'b1;
            hsb_q    <= 1'b1;
            grabbing <= 1'b0;
            col      <= '0;
            line     <= '0;
            en_q     <= 1'b0;
            sof      <= 1'b0;
            eof      <= 1'b0;
            byte_o   <= '0;
        end else begin
            sof          <= fs;
            eof          <= fe;
            byte_o.valid <= take;
            if (take) byte_o.d <= sample.d;
            if (strobe) begin
                vsb_q <= vs_b;
                hsb_q <= hs_b;
                if (fs) begin
                    line     <= '0;
                    col      <= hs_b ? '0 : CNT_W'(1);
                    grabbing <= en_q;
                end else if (!vs_b) begin
                    if (hs_b) begin
                        col <= '0;
                        if (!hsb_q && line != CNT_MAX) line <= line + 1'b1;
                    end else if (col != CNT_MAX) begin
                        col <= col + 1'b1;
                    end
                end
                if (fe) grabbing <= 1'b0;
            end
            if (en_clr)                              en_q <= 1'b0;
            else if (en_set)                         en_q <= 1'b1;
            else if (fe && grabbing && cfg.snapshot) en_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cam_word_packer.sv
module cam_word_packer
    import cam_cap_pkg::*;
#(
    parameter int unsigned WORD_BYTES = 4,
    localparam int unsigned WORD_W = WORD_BYTES * PIX_W,
    localparam int unsigned IDX_W  = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  cam_byte_t         byte_i,
    input  logic              sof,
    input  logic              ovr_clr,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              overrun
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_BYTES - 1);

    logic [WORD_W-1:0] acc_q, acc_next;
    logic [IDX_W-1:0]  idx_q, idx_eff;
    logic              full, lost;

    always_comb begin
        idx_eff  = sof ? '0 : idx_q;
        acc_next = acc_q;
        for (int b = 0; b < WORD_BYTES; b++) begin
            if (idx_eff == IDX_W'(b)) acc_next[b*PIX_W +: PIX_W] = byte_i.d;
        end
        full = byte_i.valid && (idx_eff == LAST);
        lost = full && out_valid && !out_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            idx_q     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            overrun   <= 1'b0;
        end else begin
            if (out_valid && out_ready) out_valid <= 1'b0;
            if (sof) idx_q <= '0;
            if (byte_i.valid) begin
                if (full) begin
                    idx_q <= '0;
                    if (!lost) begin
                        out_data  <= acc_next;
                        out_valid <= 1'b1;
                    end
                end else begin
                    acc_q <= acc_next;
                    idx_q <= idx_eff + 1'b1;
                end
            end
            if (ovr_clr) overrun <= 1'b0;
            if (lost)    overrun <= 1'b1;
        end
    end
endmodule

// File: rtl/cam_capture.sv
module cam_capture
    import cam_cap_pkg::*;
#(
    parameter int unsigned CNT_W      = 12,
    parameter int unsigned WORD_BYTES = 4,
    localparam int unsigned WORD_W = WORD_BYTES * PIX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pclk,
    input  logic              cam_vsync,
    input  logic              cam_hsync,
    input  logic [PIX_W-1:0]  cam_data,
    input  logic              cfg_vs_pol,
    input  logic              cfg_hs_pol,
    input  logic              cfg_pclk_rise,
    input  logic              cfg_jpeg,
    input  logic              cfg_crop_en,
    input  logic              cfg_snapshot,
    input  logic [CNT_W-1:0]  crop_col,
    input  logic [CNT_W-1:0]  crop_line,
    input  logic [CNT_W-1:0]  crop_width,
    input  logic [CNT_W-1:0]  crop_height,
    input  logic              cap_set,
    input  logic              cap_clr,
    output logic              cap_en,
    output logic              frame_start,
    output logic              frame_end,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              overrun
);
    cam_cfg_t  cfg;
    cam_pins_t pins, sample;
    cam_byte_t byte_s;
    logic      strobe;

    always_comb begin
        cfg.vs_pol    = cfg_vs_pol;
        cfg.hs_pol    = cfg_hs_pol;
        cfg.pclk_rise = cfg_pclk_rise;
        cfg.jpeg      = cfg_jpeg;
        cfg.crop_en   = cfg_crop_en;
        cfg.snapshot  = cfg_snapshot;
        pins.vs       = cam_vsync;
        pins.hs       = cam_hsync;
        pins.d        = cam_data;
    end

    cam_pclk_sampler u_sampler (
        .clk(clk), .rst(rst), .pclk(pclk), .pins(pins),
        .rise_sel(cfg.pclk_rise), .strobe(strobe), .sample(sample)
    );

    cam_frame_ctrl #(.CNT_W(CNT_W)) u_frame (
        .clk(clk), .rst(rst), .strobe(strobe), .sample(sample), .cfg(cfg),
        .win_col(crop_col), .win_line(crop_line), .win_w(crop_width), .win_h(crop_height),
        .en_set(cap_set), .en_clr(cap_clr), .byte_o(byte_s),
        .sof(frame_start), .eof(frame_end), .en_q(cap_en)
    );

    cam_word_packer #(.WORD_BYTES(WORD_BYTES)) u_pack (
        .clk(clk), .rst(rst), .byte_i(byte_s), .sof(frame_start), .ovr_clr(cap_set),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data), .overrun(overrun)
    );
endmodule

// File: rtl/cam_capture_chk.sv
module cam_capture_chk #(
    parameter int unsigned WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cap_set,
    input logic              cap_clr,
    input logic              cap_en,
    input logic              frame_start,
    input logic              frame_end,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic              overrun
);
    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(frame_start && frame_end));

    assert_en_fall_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(cap_en) |-> (frame_end || $past(cap_clr)));

    assert_ovr_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        (overrun && !cap_set) |=> overrun);

    assert_ovr_cause_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(out_valid && !out_ready));
endmodule

bind cam_capture cam_capture_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst(rst), .cap_set(cap_set), .cap_clr(cap_clr), .cap_en(cap_en),
    .frame_start(frame_start), .frame_end(frame_end), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .overrun(overrun)
);

// File: tb/cam_capture_test.sv
module cam_capture_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        pclk = 1'b0, cam_vsync = 1'b0, cam_hsync = 1'b0;
    logic [7:0]  cam_data = '0;
    logic        cfg_vs_pol = 0, cfg_hs_pol = 0, cfg_pclk_rise = 1;
    logic        cfg_jpeg = 0, cfg_crop_en = 0, cfg_snapshot = 0;
    logic [11:0] crop_col = '0, crop_line = '0, crop_width = '0, crop_height = '0;
    logic        cap_set = 0, cap_clr = 0, out_ready = 1;
    logic        cap_en, frame_start, frame_end, out_valid, overrun;
    logic [31:0] out_data;

    cam_capture uut (.*);

    int checks = 0, fails = 0, fs_cnt = 0, fe_cnt = 0;
    logic [31:0] got_w[$];
    logic [31:0] exp_w[$];

    always @(negedge clk) if (!rst) begin
        if (out_valid && out_ready) got_w.push_back(out_data);
        if (frame_start) fs_cnt++;
        if (frame_end) fe_cnt++;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse(ref logic s);
        @(posedge clk); #1 s = 1'b1;
        @(posedge clk); #1 s = 1'b0;
    endtask

    // one pixel period: idle level, then data, then capture edge
    task automatic pix(input bit vblank, input bit hblank, input logic [7:0] d);
        @(posedge clk); #1 pclk = ~cfg_pclk_rise;
        repeat (2) @(posedge clk);
        #1 cam_vsync = vblank ? cfg_vs_pol : ~cfg_vs_pol;
        cam_hsync = hblank ? cfg_hs_pol : ~cfg_hs_pol;
        cam_data  = d;
        repeat (2) @(posedge clk);
        #1 pclk = cfg_pclk_rise;
        repeat (3) @(posedge clk);
    endtask

    function automatic logic [7:0] pv(input int seed, input int l, input int c);
        return 8'(seed + l * 13 + c * 3 + 1);
    endfunction

    function automatic bit in_win(input int l, input int c);
        if (cfg_jpeg || !cfg_crop_en) return 1;
        return c >= int'(crop_col) && c < int'(crop_col) + int'(crop_width) &&
               l >= int'(crop_line) && l < int'(crop_line) + int'(crop_height);
    endfunction

    task automatic frame(input int lines, input int cols, input int seed,
                         input bit expect_cap, input int set_line, input bit gap);
        logic [7:0] fb[$];
        pix(1, 0, 8'hEE);          // vertical blanking, hsync active: ignored (R1)
        pix(1, 0, 8'hEF);
        for (int l = 0; l < lines; l++) begin
            if (l == set_line) pulse(cap_set);
            pix(0, 1, 8'hAA);      // horizontal blanking: ignored (R2)
            pix(0, 1, 8'hAB);
            for (int c = 0; c < cols; c++) begin
                if (gap && c == 2) pix(0, 1, 8'h55);
                pix(0, 0, pv(seed, l, c));
                if (expect_cap && in_win(l, c)) fb.push_back(pv(seed, l, c));
            end
        end
        pix(0, 1, 8'hAC);
        pix(1, 1, 8'hBA);
        pix(1, 0, 8'hBB);
        for (int w = 0; w + 3 < fb.size(); w += 4)
            exp_w.push_back({fb[w+3], fb[w+2], fb[w+1], fb[w]});
    endtask

    task automatic compare(input string tag);
        repeat (10) @(posedge clk);
        chk(got_w.size() == exp_w.size(), {tag, " word count"}, got_w.size(), exp_w.size());
        for (int i = 0; i < got_w.size() && i < exp_w.size(); i++)
            chk(got_w[i] === exp_w[i], tag, got_w[i], exp_w[i]);
        got_w.delete();
        exp_w.delete();
    endtask

    task automatic t_reset;
        #2;
        chk(out_valid === 0, "R13 out_valid", out_valid, 0);
        chk(cap_en === 0, "R13 cap_en", cap_en, 0);
        chk(overrun === 0, "R13 overrun", overrun, 0);
        chk(frame_start === 0 && frame_end === 0, "R13 pulses", {frame_start, frame_end}, 0);
    endtask

    task automatic t_continuous;
        int f0;
        f0 = fs_cnt;
        pulse(cap_set);
        frame(3, 4, 10, 1, -1, 0);
        chk(got_w.size() > 0 && got_w[0] === {pv(10,0,3), pv(10,0,2), pv(10,0,1), pv(10,0,0)},
            "R4 byte order", got_w.size() > 0 ? got_w[0] : 0,
            {pv(10,0,3), pv(10,0,2), pv(10,0,1), pv(10,0,0)});
        frame(3, 4, 40, 1, -1, 0);
        compare("R8 continuous frames");
        chk(fs_cnt - f0 == 2, "R10 frame_start count", fs_cnt - f0, 2);
        frame(2, 3, 70, 1, -1, 0);   // 6 bytes: 2 left over
        frame(1, 4, 90, 1, -1, 0);
        compare("R4 partial word dropped");
    endtask

    task automatic t_polarity;
        cfg_vs_pol = 1; cfg_hs_pol = 1;
        frame(2, 4, 5, 1, -1, 0);
        compare("R1 R2 high blanking levels");
        cfg_vs_pol = 0; cfg_hs_pol = 0;
    endtask

    task automatic t_falling;
        cfg_pclk_rise = 0;
        frame(2, 4, 33, 1, -1, 0);
        compare("R3 falling edge");
        cfg_pclk_rise = 1;
        frame(1, 4, 51, 1, -1, 0);
        compare("R3 rising edge");
    endtask

    task automatic t_crop;
        cfg_crop_en = 1;
        crop_col = 2; crop_width = 4; crop_line = 1; crop_height = 2;
        frame(4, 8, 7, 1, -1, 0);
        compare("R5 crop window");
        crop_col = 6; crop_width = 8; crop_line = 2; crop_height = 10;
        frame(4, 8, 19, 1, -1, 0);
        compare("R6 crop clipped");
        cfg_crop_en = 0;
    endtask

    task automatic t_jpeg;
        cfg_jpeg = 1; cfg_crop_en = 1;
        crop_col = 0; crop_width = 1; crop_line = 0; crop_height = 1;
        frame(2, 4, 61, 1, -1, 1);
        compare("R7 jpeg data enable");
        cfg_jpeg = 0; cfg_crop_en = 0;
    endtask

    task automatic t_snapshot;
        pulse(cap_clr);
        cfg_snapshot = 1;
        frame(3, 4, 3, 0, 1, 0);     // enabled mid-frame: not captured
        chk(cap_en === 1, "R9 enable held until frame", cap_en, 1);
        frame(2, 4, 23, 1, -1, 0);
        chk(cap_en === 0, "R9 cap_en cleared", cap_en, 0);
        frame(2, 4, 47, 0, -1, 0);
        compare("R9 snapshot single frame");
        cfg_snapshot = 0;
    endtask

    task automatic t_disabled;
        int s0, e0;
        s0 = fs_cnt; e0 = fe_cnt;
        frame(2, 4, 12, 0, -1, 0);
        chk(fs_cnt - s0 == 1 && fe_cnt - e0 == 1, "R10 pulses while disabled",
            {fs_cnt - s0, fe_cnt - e0}, {32'd1, 32'd1});
        compare("R10 nothing captured while disabled");
    endtask

    task automatic t_overrun;
        pulse(cap_set);
        out_ready = 0;
        frame(1, 12, 99, 1, -1, 0);
        #2;
        chk(out_valid === 1, "R11 word held", out_valid, 1);
        chk(out_data === exp_w[0], "R11 held data", out_data, exp_w[0]);
        chk(overrun === 1, "R12 overrun set", overrun, 1);
        exp_w = exp_w[0:0];
        @(posedge clk); #1 out_ready = 1;
        compare("R12 only first word delivered");
        chk(overrun === 1, "R12 overrun sticky", overrun, 1);
        pulse(cap_set);
        #2;
        chk(overrun === 0, "R12 cleared by cap_set", overrun, 0);
        pulse(cap_clr);
        #2;
        chk(cap_en === 0, "R13 cap_clr", cap_en, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_continuous();
        t_polarity();
        t_falling();
        t_crop();
        t_jpeg();
        t_snapshot();
        t_disabled();
        t_overrun();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule